// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Controller

This block chooses the system clock between a free-running internal oscillator clock and an external crystal clock. While the crystal settles, the system runs from the internal clock. A start-up timer counts rising edges of the external clock. When the count is complete, the block hands the system clock over to the external source through a glitch-free gating pair.

The handover is break-before-make. Each source branch is enabled and disabled only while its own clock is low. A branch is enabled only after the other branch has been seen off through a synchronizer. The start-up timer re-arms from zero on every event that could have left the crystal unsettled: a master reset, sleep, and a new request for the external source.

The block also keeps two status flags for the internal oscillator. The ready flag and the stable flag rise a set number of internal clock cycles after that oscillator is enabled. Both flags fall again as soon as the oscillator is disabled.

Top module: `tsclk_ctrl`

## Requirements
- R1: While `rst_n` is low, `sys_clk`, `ost_done`, `int_rdy` and `int_stable` are all held at 0, whatever the other inputs do.
- R2: With `ext_sel` = 1 (external requested) and `sleep_req` = 0, `ost_done` rises after OST_CYCLES (default 1024) rising edges of `ext_clk`, counted once the request has crossed a SYNC_STAGES synchronizer. It is still 0 six edges before that point and 1 shortly after.
- R3: As long as `ost_done` is 0, `sys_clk` follows `int_clk`.
- R4: After `ost_done` rises, `sys_clk` stays low until a falling edge of `ext_clk`. From then on it follows `ext_clk`, with every rising edge of `sys_clk` aligned to a rising edge of `ext_clk`.
- R5: `sleep_req` = 1 clears `ost_done` and returns the system to the internal clock. Wake (`sleep_req` going 0) restarts the count from zero.
- R6: Dropping `ext_sel` clears `ost_done`. Raising it again restarts the full count from zero.
- R7: A master reset in the middle of a count discards the partial count. After release, the full OST_CYCLES count is needed again.
- R8: On a switch back to internal, the external branch is gated off at an `ext_clk` falling edge before the internal branch is enabled at an `int_clk` falling edge. `sys_clk` then follows `int_clk` again.
- R9: The two branches are never enabled together. `sys_clk` never shows a high or low phase shorter than the shorter half-period of the two source clocks.
- R10: With `int_osc_en` = 1, `int_rdy` rises RDY_CYCLES and `int_stable` rises STB_CYCLES synchronized `int_clk` cycles later. `int_stable` = 1 implies `int_rdy` = 1.
- R11: Within SYNC_STAGES + 2 `int_clk` cycles of `int_osc_en` going 0, both `int_rdy` and `int_stable` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Internal oscillator clock |
| ext_clk | input | 1 | External crystal clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| sleep_req | input | 1 | 1 = sleep; the falling edge is a wake |
| int_osc_en | input | 1 | 1 = internal oscillator enabled (drives the status flags) |
| ext_sel | input | 1 | Clock-select request: 1 = external, 0 = internal |
| sys_clk | output | 1 | Gated system clock |
| ost_done | output | 1 | Start-up timer complete (external-clock domain) |
| int_rdy | output | 1 | Internal oscillator ready flag |
| int_stable | output | 1 | Internal oscillator stable flag |

## Verification
A start-up counter stuck or cut short shows up first at `ost_done`. It also shows up a few external cycles later as the wrong `sys_clk` period, because the handover follows `done` within a synchronizer depth. A mistake in the gating pair, such as a missing break-before-make or an enable changing on the wrong edge, shows at the first handover as a phase narrower than either source half-period, or as `sys_clk` edges that do not line up with the chosen source. A flag counter that fails to clear shows at `int_rdy` and `int_stable` within a few internal cycles of disable.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;
   // width of a counter that must hold values 0..n
   function automatic int cnt_w(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/tsc_sync.sv
`timescale 1ns/1ps
module tsc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-2:0], d};
   end

   assign q = shreg[STAGES-1];
endmodule

// File: rtl/tsc_ost.sv
`timescale 1ns/1ps
module tsc_ost
   import tsc_pkg::*;
#(
   parameter int CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int W = cnt_w(CYCLES);
   localparam logic [W-1:0] LAST = W'(CYCLES - 1);

   logic [W-1:0] cnt;

   // any drop of run re-arms the timer from zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!done) begin
         if (cnt == LAST) done <= 1'b1;
         else             cnt  <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/tsc_gate.sv
`timescale 1ns/1ps
module tsc_gate #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic other_on,
   output logic on
);
   logic want_s;
   logic other_s;

   tsc_sync #(.STAGES(SYNC_STAGES)) u_want (
      .clk(clk), .rst_n(rst_n), .d(want), .q(want_s));
   tsc_sync #(.STAGES(SYNC_STAGES)) u_other (
      .clk(clk), .rst_n(rst_n), .d(other_on), .q(other_s));

   // enable changes only while this branch's clock is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) on <= 1'b0;
      else        on <= want_s & ~other_s;
   end
endmodule

// File: rtl/tsc_flags.sv
`timescale 1ns/1ps
module tsc_flags
   import tsc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RDY_CYCLES  = 4,
   parameter int STB_CYCLES  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_en,
   output logic en_s,
   output logic rdy,
   output logic stable
);
   localparam int W = cnt_w(STB_CYCLES);
   localparam logic [W-1:0] RDY_AT = W'(RDY_CYCLES - 1);
   localparam logic [W-1:0] STB_AT = W'(STB_CYCLES - 1);
   localparam logic [W-1:0] SAT    = W'(STB_CYCLES);

   logic [W-1:0] cnt;

   tsc_sync #(.STAGES(SYNC_STAGES)) u_en (
      .clk(clk), .rst_n(rst_n), .d(osc_en), .q(en_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         rdy    <= 1'b0;
         stable <= 1'b0;
      end else if (!en_s) begin
         cnt    <= '0;
         rdy    <= 1'b0;
         stable <= 1'b0;
      end else begin
         if (cnt != SAT) cnt <= cnt + 1'b1;
         if (cnt >= RDY_AT) rdy    <= 1'b1;
         if (cnt >= STB_AT) stable <= 1'b1;
      end
   end
endmodule

// File: rtl/tsclk_ctrl.sv
`timescale 1ns/1ps
module tsclk_ctrl #(
   parameter int OST_CYCLES  = 1024,
   parameter int SYNC_STAGES = 2,
   parameter int RDY_CYCLES  = 4,
   parameter int STB_CYCLES  = 16
) (
   input  logic int_clk,
   input  logic ext_clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic int_osc_en,
   input  logic ext_sel,
   output logic sys_clk,
   output logic ost_done,
   output logic int_rdy,
   output logic int_stable
);
   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tsclk_ctrl: SYNC_STAGES must be at least 2");
   end
   if (OST_CYCLES < 2) begin : g_bad_ost
      $error("tsclk_ctrl: OST_CYCLES must be at least 2");
   end
   if (RDY_CYCLES < 1 || STB_CYCLES < RDY_CYCLES) begin : g_bad_flags
      $error("tsclk_ctrl: need 1 <= RDY_CYCLES <= STB_CYCLES");
   end

   logic req_x;
   logic slp_x;
   logic ost_run;
   logic sel_ext_q;
   logic int_want;
   logic int_on;
   logic ext_on;
   logic int_en_s;

   // request and sleep brought into the crystal domain
   tsc_sync #(.STAGES(SYNC_STAGES)) u_req_x (
      .clk(ext_clk), .rst_n(rst_n), .d(ext_sel), .q(req_x));
   tsc_sync #(.STAGES(SYNC_STAGES)) u_slp_x (
      .clk(ext_clk), .rst_n(rst_n), .d(sleep_req), .q(slp_x));

   assign ost_run = req_x & ~slp_x;

   tsc_ost #(.CYCLES(OST_CYCLES)) u_ost (
      .clk(ext_clk), .rst_n(rst_n), .run(ost_run), .done(ost_done));

   // registered source choice, safe to cross into the other domain
   always_ff @(posedge ext_clk or negedge rst_n) begin
      if (!rst_n) sel_ext_q <= 1'b0;
      else        sel_ext_q <= req_x & ost_done;
   end

   assign int_want = ~sel_ext_q;

   tsc_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate_int (
      .clk(int_clk), .rst_n(rst_n), .want(int_want),
      .other_on(ext_on), .on(int_on));

   tsc_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate_ext (
      .clk(ext_clk), .rst_n(rst_n), .want(sel_ext_q),
      .other_on(int_on), .on(ext_on));

   assign sys_clk = (int_clk & int_on) | (ext_clk & ext_on);

   tsc_flags #(
      .SYNC_STAGES(SYNC_STAGES),
      .RDY_CYCLES (RDY_CYCLES),
      .STB_CYCLES (STB_CYCLES)
   ) u_flags (
      .clk(int_clk), .rst_n(rst_n), .osc_en(int_osc_en),
      .en_s(int_en_s), .rdy(int_rdy), .stable(int_stable));
endmodule

// File: rtl/tsclk_ctrl_chk.sv
`timescale 1ns/1ps
module tsclk_ctrl_chk (
   input logic int_clk,
   input logic ext_clk,
   input logic rst_n,
   input logic int_on,
   input logic ext_on,
   input logic ost_run,
   input logic ost_done,
   input logic int_en_s,
   input logic int_rdy,
   input logic int_stable
);
   // R9
   both_on_chk: assert property (@(posedge int_clk) disable iff (!rst_n)
      !(int_on && ext_on));

   // R4
   ext_after_int_chk: assert property (@(posedge ext_clk) disable iff (!rst_n)
      $rose(ext_on) |-> !int_on);

   // R5
   done_idle_chk: assert property (@(posedge ext_clk) disable iff (!rst_n)
      !ost_run |=> !ost_done);

   // R10
   stb_rdy_chk: assert property (@(posedge int_clk) disable iff (!rst_n)
      int_stable |-> int_rdy);

   // R11
   flag_clr_chk: assert property (@(posedge int_clk) disable iff (!rst_n)
      !int_en_s |=> (!int_rdy && !int_stable));
endmodule

bind tsclk_ctrl tsclk_ctrl_chk u_chk (
   .int_clk   (int_clk),
   .ext_clk   (ext_clk),
   .rst_n     (rst_n),
   .int_on    (int_on),
   .ext_on    (ext_on),
   .ost_run   (ost_run),
   .ost_done  (ost_done),
   .int_en_s  (int_en_s),
   .int_rdy   (int_rdy),
   .int_stable(int_stable)
);

// File: tb/tsclk_ctrl_bench.sv
`timescale 1ns/1ps
module tsclk_ctrl_bench;
   localparam int  OST = 1024;
   localparam int  RDY = 4;
   localparam int  STB = 16;
   localparam real TI  = 2.0;
   localparam real TE  = 3.1;

   logic int_clk    = 1'b0;
   logic ext_clk    = 1'b0;
   logic rst_n      = 1'b0;
   logic sleep_req  = 1'b0;
   logic int_osc_en = 1'b0;
   logic ext_sel    = 1'b0;
   logic sys_clk, ost_done, int_rdy, int_stable;

   int  checks    = 0;
   int  fails     = 0;
   int  short_cnt = 0;
   bit  mon_en    = 1'b0;
   real last_t    = 0.0;
   real last_ext_rise = 0.0;

   always #2.0 int_clk = ~int_clk;
   initial begin
      #1.3;
      forever #3.1 ext_clk = ~ext_clk;
   end

   tsclk_ctrl u_tsclk_ctrl (
      .int_clk(int_clk), .ext_clk(ext_clk), .rst_n(rst_n),
      .sleep_req(sleep_req), .int_osc_en(int_osc_en), .ext_sel(ext_sel),
      .sys_clk(sys_clk), .ost_done(ost_done),
      .int_rdy(int_rdy), .int_stable(int_stable));

   always @(posedge ext_clk) last_ext_rise = $realtime;

   // phase-width monitor for R9
   always @(sys_clk) begin
      real w;
      w = $realtime - last_t;
      if (mon_en && last_t > 0.0 && w < TI - 0.01) short_cnt++;
      last_t = $realtime;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic real exp_period(input bit sel, input bit slp);
      return (sel && !slp) ? 2.0 * TE : 2.0 * TI;
   endfunction

   function automatic bit exp_done(input bit sel, input bit slp);
      return sel && !slp;
   endfunction

   task automatic wait_ext(input int n);
      repeat (n) @(posedge ext_clk);
      #0.5;
   endtask

   task automatic wait_int(input int n);
      repeat (n) @(posedge int_clk);
      #1.0;
   endtask

   task automatic chk_period(input real exp, input string req);
      real t0, p;
      @(posedge sys_clk);
      t0 = $realtime;
      @(posedge sys_clk);
      p = $realtime - t0;
      chk((p > exp - 0.05) && (p < exp + 0.05), req, $rtoi(p * 1000.0), $rtoi(exp * 1000.0));
   endtask

   task automatic chk_align(input string req);
      real t;
      @(posedge sys_clk);
      t = $realtime;
      #0.1;
      chk((t - last_ext_rise) < 0.01 && (t - last_ext_rise) > -0.01, req,
          $rtoi((t - last_ext_rise) * 1000.0), 0);
   endtask

   // full count from a fresh arm point (request, wake or reset release)
   task automatic count_check(input string tag);
      wait_ext(OST - 6);
      chk(ost_done == 1'b0, {tag, " R2 done early"}, int'(ost_done), 0);
      chk_period(2.0 * TI, {tag, " R3 internal during count"});
      wait_ext(14);
      chk(ost_done == 1'b1, {tag, " R2 done after count"}, int'(ost_done), 1);
      wait_ext(12);
      chk_period(2.0 * TE, {tag, " R4 external after done"});
      chk_align({tag, " R4 edge alignment"});
   endtask

   initial begin
      #600000;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      // R1: reset state with other inputs active
      int_osc_en = 1'b1;
      ext_sel    = 1'b1;
      repeat (3) begin
         wait_int(3);
         chk(sys_clk == 1'b0, "R1 sys_clk in reset", int'(sys_clk), 0);
      end
      chk(ost_done == 1'b0, "R1 ost_done in reset", int'(ost_done), 0);
      chk(int_rdy == 1'b0 && int_stable == 1'b0, "R1 flags in reset",
          int'({int_rdy, int_stable}), 0);
      @(negedge int_clk);
      int_osc_en = 1'b0;
      ext_sel    = 1'b0;
      rst_n      = 1'b1;
      mon_en     = 1'b1;

      // R3: internal clock by default
      wait_int(10);
      chk_period(2.0 * TI, "R3 internal after reset");

      // R10 / R11: oscillator flags
      @(negedge int_clk);
      int_osc_en = 1'b1;
      wait_int(2);
      chk(int_rdy == 1'b0, "R10 rdy too early", int'(int_rdy), 0);
      wait_int(RDY + 3);
      chk(int_rdy == 1'b1, "R10 rdy set", int'(int_rdy), 1);
      chk(int_stable == 1'b0, "R10 stable too early", int'(int_stable), 0);
      wait_int(STB);
      chk(int_stable == 1'b1, "R10 stable set", int'(int_stable), 1);
      @(negedge int_clk);
      int_osc_en = 1'b0;
      wait_int(4);
      chk(int_rdy == 1'b0 && int_stable == 1'b0, "R11 flags clear on disable",
          int'({int_rdy, int_stable}), 0);

      // R2 / R3 / R4: first start-up
      @(negedge int_clk);
      ext_sel = 1'b1;
      count_check("first");

      // R5: sleep clears, wake restarts
      @(negedge int_clk);
      sleep_req = 1'b1;
      wait_ext(20);
      chk(ost_done == 1'b0, "R5 done cleared in sleep", int'(ost_done), 0);
      chk_period(2.0 * TI, "R5 internal in sleep");
      @(negedge int_clk);
      sleep_req = 1'b0;
      count_check("R5 wake");

      // R6 / R8: switch back to internal, then request again
      @(negedge int_clk);
      ext_sel = 1'b0;
      wait_ext(20);
      chk(ost_done == 1'b0, "R6 done cleared on deselect", int'(ost_done), 0);
      chk_period(2.0 * TI, "R8 internal after switch back");
      @(negedge int_clk);
      ext_sel = 1'b1;
      count_check("R6 reselect");

      // R7: reset mid-count
      @(negedge int_clk);
      ext_sel = 1'b0;
      wait_ext(20);
      @(negedge int_clk);
      ext_sel = 1'b1;
      wait_ext(500);
      mon_en = 1'b0;
      @(negedge int_clk);
      rst_n = 1'b0;
      wait_int(3);
      chk(ost_done == 1'b0 && sys_clk == 1'b0, "R7 reset mid-count",
          int'({ost_done, sys_clk}), 0);
      @(negedge int_clk);
      rst_n  = 1'b1;
      last_t = 0.0;
      mon_en = 1'b1;
      count_check("R7 after reset");

      // random phases: bursts of input changes, then settle and compare
      for (int r = 0; r < 6; r++) begin
         for (int k = 0; k < 4; k++) begin
            @(negedge int_clk);
            ext_sel    = 1'($urandom % 2);
            sleep_req  = 1'($urandom % 2);
            int_osc_en = 1'($urandom % 2);
            repeat ($urandom_range(1, 40)) @(posedge int_clk);
         end
         wait_ext(OST + 40);
         chk(ost_done == exp_done(ext_sel, sleep_req), "R2 R5 R6 random done",
             int'(ost_done), int'(exp_done(ext_sel, sleep_req)));
         chk_period(exp_period(ext_sel, sleep_req), "R3 R4 random period");
         chk(int_rdy == int_osc_en && int_stable == int_osc_en, "R10 R11 random flags",
             int'({int_rdy, int_stable}), int'({int_osc_en, int_osc_en}));
      end

      // R9: no short phase seen anywhere in the run
      chk(short_cnt == 0, "R9 short phase count", short_cnt, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule